// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. A host drives a chip-select strobe and a mode line. The block counts the falling edges of the strobe and reads the mode line at each one, so a single strobe pin moves the block through acquisition, conversion and read-out. During conversion the block presents a trial code to an external DAC. It takes back a single comparator bit and resolves one result bit per clock, starting at the most significant bit. The analog parts are outside the block; the comparator is an ordinary input.

When the search finishes, the block pulls its completion flag low and holds the result in an output register. A later strobe edge, with the mode line high, drives the result onto the data bus. The bus is either the full width, or half width with a select input choosing the upper or lower half. At the conversion-start edge the block also records whether the reference should be powered down after the conversion, and it shows that choice on a power-down output. The bus output comes as a data vector plus an enable; enable low stands for high impedance. The strobe and mode inputs are asynchronous to the clock and pass through a two-flop synchroniser before edge detection.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After asynchronous reset, the block is idle. `conv_done_no` is 1, `bus_oe_o` is 0 and `pwr_down_o` is 0.
- R2: In idle, a falling edge of `cs_ni` with `read_sel_i` high is ignored. Only the next falling edge with `read_sel_i` low enters acquisition, so a conversion needs one further edge after that.
- R3: In acquisition, the next falling edge of `cs_ni` starts a conversion. `conv_done_no` falls within DATA_W+8 clocks of that edge.
- R4: The result is straight binary. It is the largest code whose trial value the comparator reports as at or below the input. An input of 0 gives 0, and full scale gives 2^DATA_W-1.
- R5: The search tests one bit per clock, most significant first. The first trial is 2^(DATA_W-1), and a zero input produces exactly DATA_W one-hot trials. `trial_o` is 0 whenever no search is running.
- R6: The level of `read_sel_i` at the conversion-start edge is latched. From the end of conversion, `pwr_down_o` shows that level (1 = shut down, 0 = standby) through read-out. It clears when the next acquisition starts.
- R7: `conv_done_no` goes low at the end of conversion and stays low through read-out. It returns high once `cs_ni` rises after the read edge.
- R8: `bus_oe_o` is 0 during idle, acquisition, conversion and while waiting after completion. It goes to 1 only after a falling edge of `cs_ni` with `read_sel_i` high once the conversion is done, and it returns to 0 when `cs_ni` rises.
- R9: With BYTE_BUS=1, `bus_o` carries result bits [DATA_W-1:DATA_W/2] while `half_sel_i` is 1 and bits [DATA_W/2-1:0] while it is 0. With BYTE_BUS=0, `bus_o` carries the whole result. The value on the bus holds steady while it is driven.
- R10: Strobe edges during a conversion are ignored. After completion, a falling edge with `read_sel_i` low is also ignored. Neither changes the result, the completion flag or the bus enable.
- R11: `clear_i` high returns the block to idle. It sets `conv_done_no` to 1 and `bus_oe_o` and `pwr_down_o` to 0. The next falling edge with `read_sel_i` low starts acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous active-high return to idle |
| cs_ni | input | 1 | Chip-select strobe, asynchronous, active low |
| read_sel_i | input | 1 | Mode line sampled at strobe falling edges |
| half_sel_i | input | 1 | Byte bus half select (1 = upper) |
| cmp_ge_i | input | 1 | Comparator: input at or above trial level |
| trial_o | output | DATA_W | Trial code to the DAC |
| conv_done_no | output | 1 | Completion flag, active low |
| bus_o | output | BUS_W | Result data (0 when not enabled) |
| bus_oe_o | output | 1 | Bus drive enable; 0 means high impedance |
| pwr_down_o | output | 1 | Reference power-down request |

## Verification
The assertions check the following on every clock:
- the bus is never driven unless the completion flag is low;
- the flag never falls while the bus is driven, and rises only after a read or a clear;
- the first trial after a conversion starts is the most significant bit;
- the power-down output and the driven bus value stay stable while they should;
- a clear always leads to the idle outputs.

Only the bench scenarios can show the rest:
- the value of each conversion result;
- that ignored strobe edges really leave the phase count untouched;
- the half-select mapping;
- that the power-down flag clears on the next acquisition.

Every code of a 10-bit word-wide configuration is swept against a 16-bit byte-wide one.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ACQ  = 3'd1,
    PH_CONV = 3'd2,
    PH_DONE = 3'd3,
    PH_READ = 3'd4
  } phase_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              cmp_ge_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] code_o,
  output logic              done_o
);
  localparam logic [DATA_W-1:0] MSB = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] mask_q, code_q;
  logic              done_q;
  logic              busy;

  assign busy = |mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      mask_q <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      mask_q <= MSB;
      code_q <= '0;
      done_q <= 1'b0;
    end else if (busy) begin
      if (cmp_ge_i) code_q <= code_q | mask_q;
      mask_q <= mask_q >> 1;
      done_q <= mask_q[0];
    end else begin
      done_q <= 1'b0;
    end
  end

  assign trial_o = busy ? (code_q | mask_q) : '0;
  assign code_o  = code_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sar_bus_mux.sv
module sar_bus_mux #(
  parameter int DATA_W   = 16,
  parameter bit BYTE_BUS = 1'b0,
  localparam int BUS_W   = BYTE_BUS ? DATA_W/2 : DATA_W
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              oe_i,
  input  logic              half_sel_i,
  output logic [BUS_W-1:0]  bus_o
);
  logic [BUS_W-1:0] sel;

  if (BYTE_BUS) begin : g_half
    assign sel = half_sel_i ? res_i[DATA_W-1:BUS_W] : res_i[BUS_W-1:0];
  end else begin : g_full
    logic unused_sel;
    assign unused_sel = half_sel_i;
    assign sel = res_i;
  end

  assign bus_o = oe_i ? sel : '0;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter bit BYTE_BUS    = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = BYTE_BUS ? DATA_W/2 : DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cs_ni,
  input  logic              read_sel_i,
  input  logic              half_sel_i,
  input  logic              cmp_ge_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              conv_done_no,
  output logic [BUS_W-1:0]  bus_o,
  output logic              bus_oe_o,
  output logic              pwr_down_o
);
  logic [1:0] sync_q;
  logic       cs_s, rd_s, cs_d;
  logic       cs_fall, cs_rise;

  sar_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({read_sel_i, cs_ni}),
    .q_o   (sync_q)
  );
  assign cs_s = sync_q[0];
  assign rd_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_d <= 1'b1;
    else cs_d <= cs_s;
  end
  assign cs_fall = cs_d & ~cs_s;
  assign cs_rise = ~cs_d & cs_s;

  phase_e            phase_q;
  logic              sd_q, pwr_q, done_nq;
  logic [DATA_W-1:0] res_q, code;
  logic              conv_start, srch_done;

  assign conv_start = (phase_q == PH_ACQ) && cs_fall;

  sar_search #(.DATA_W(DATA_W)) u_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .start_i (conv_start),
    .cmp_ge_i(cmp_ge_i),
    .trial_o (trial_o),
    .code_o  (code),
    .done_o  (srch_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      sd_q    <= 1'b0;
      pwr_q   <= 1'b0;
      done_nq <= 1'b1;
      res_q   <= '0;
    end else if (clear_i) begin
      phase_q <= PH_IDLE;
      sd_q    <= 1'b0;
      pwr_q   <= 1'b0;
      done_nq <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (cs_fall && !rd_s) begin
          phase_q <= PH_ACQ;
          pwr_q   <= 1'b0;
        end
        PH_ACQ: if (cs_fall) begin
          phase_q <= PH_CONV;
          sd_q    <= rd_s;
        end
        PH_CONV: if (srch_done) begin
          phase_q <= PH_DONE;
          res_q   <= code;
          done_nq <= 1'b0;
          pwr_q   <= sd_q;
        end
        PH_DONE: if (cs_fall && rd_s) phase_q <= PH_READ;
        PH_READ: if (cs_rise) begin
          phase_q <= PH_IDLE;
          done_nq <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bus_oe_o     = (phase_q == PH_READ);
  assign conv_done_no = done_nq;
  assign pwr_down_o   = pwr_q;

  sar_bus_mux #(.DATA_W(DATA_W), .BYTE_BUS(BYTE_BUS)) u_mux (
    .res_i     (res_q),
    .oe_i      (bus_oe_o),
    .half_sel_i(half_sel_i),
    .bus_o     (bus_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              half_sel_i,
  input logic              conv_start,
  input logic [DATA_W-1:0] trial_o,
  input logic              conv_done_no,
  input logic [BUS_W-1:0]  bus_o,
  input logic              bus_oe_o,
  input logic              pwr_down_o
);
  localparam logic [DATA_W-1:0] MSB = {1'b1, {(DATA_W-1){1'b0}}};

  // R8
  oe_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> !conv_done_no);

  // R8
  oe_off_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_done_no) |-> !bus_oe_o);

  // R7
  done_rise_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_done_no) |-> ($past(bus_oe_o) || $past(clear_i)));

  // R11
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (conv_done_no && !bus_oe_o && !pwr_down_o));

  // R5
  msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start && !clear_i) |=> (trial_o == MSB));

  // R9
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && $past(bus_oe_o) && $stable(half_sel_i)) |-> $stable(bus_o));

  // R6
  pwr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_no && $past(!conv_done_no)) |-> $stable(pwr_down_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .half_sel_i  (half_sel_i),
  .conv_start  (conv_start),
  .trial_o     (trial_o),
  .conv_done_no(conv_done_no),
  .bus_o       (bus_o),
  .bus_oe_o    (bus_oe_o),
  .pwr_down_o  (pwr_down_o)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  localparam int WA = 10;
  localparam int WB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic cs_n = 1'b1;
  logic rsel = 1'b0;
  logic half = 1'b0;
  logic [WA-1:0] vin_a = '0;
  logic [WB-1:0] vin_b = '0;
  logic [WA-1:0] trial_a, bus_a;
  logic [WB-1:0] trial_b;
  logic [WB/2-1:0] bus_b;
  logic done_a, done_b, oe_a, oe_b, pd_a, pd_b;
  logic cmp_a, cmp_b;
  int checks = 0, errors = 0;
  bit mon_en = 1'b0;
  int cnt_a = 0, cnt_b = 0;
  logic [WB-1:0] first_a = '0, first_b = '0;

  always #2.5 clk = ~clk;

  assign cmp_a = (vin_a >= trial_a);
  assign cmp_b = (vin_b >= trial_b);

  sar_conv_ctrl #(.DATA_W(WA), .BYTE_BUS(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .cs_ni(cs_n),
    .read_sel_i(rsel), .half_sel_i(half), .cmp_ge_i(cmp_a),
    .trial_o(trial_a), .conv_done_no(done_a), .bus_o(bus_a),
    .bus_oe_o(oe_a), .pwr_down_o(pd_a));

  sar_conv_ctrl #(.DATA_W(WB), .BYTE_BUS(1'b1)) uut_byte (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .cs_ni(cs_n),
    .read_sel_i(rsel), .half_sel_i(half), .cmp_ge_i(cmp_b),
    .trial_o(trial_b), .conv_done_no(done_b), .bus_o(bus_b),
    .bus_oe_o(oe_b), .pwr_down_o(pd_b));

  always @(negedge clk) if (mon_en) begin
    if ($onehot(trial_a)) begin if (cnt_a == 0) first_a = WB'(trial_a); cnt_a++; end
    if ($onehot(trial_b)) begin if (cnt_b == 0) first_b = trial_b; cnt_b++; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic rs);
    rsel = rs; cs_n = 1'b0; cyc(4); cs_n = 1'b1; cyc(4);
  endtask

  task automatic idle_state(input string req);
    chk(done_a && done_b, req, {done_a, done_b}, 2'b11);
    chk(!oe_a && !oe_b, req, {oe_a, oe_b}, 2'b00);
    chk(!pd_a && !pd_b, req, {pd_a, pd_b}, 2'b00);
  endtask

  // acquire, convert with shutdown choice sd, optionally poke the strobe mid-conversion
  task automatic convert(input logic sd, input bit poke);
    strobe(1'b0);
    rsel = sd; cs_n = 1'b0; cyc(4); cs_n = 1'b1; cyc(2);
    if (poke) begin
      rsel = 1'b1; cs_n = 1'b0; cyc(3); cs_n = 1'b1; cyc(3);
      rsel = 1'b0; cs_n = 1'b0; cyc(3); cs_n = 1'b1; cyc(3);
      chk(!oe_a && !oe_b, "R10 no bus during conversion", {oe_a, oe_b}, 2'b00);
      cyc(12);
    end else cyc(WB + 8);
    chk(!done_a && !done_b, "R3 done low after conversion", {done_a, done_b}, 2'b00);
    chk(!oe_a && !oe_b, "R8 bus released before read", {oe_a, oe_b}, 2'b00);
    chk(pd_a == sd && pd_b == sd, "R6 power-down follows choice", {pd_a, pd_b}, {sd, sd});
  endtask

  task automatic read_check(input logic sd, input string req);
    rsel = 1'b1; cs_n = 1'b0; cyc(4);
    chk(oe_a && oe_b, "R8 bus driven on read", {oe_a, oe_b}, 2'b11);
    chk(!done_a, "R7 done stays low during read", done_a, 0);
    chk(bus_a == vin_a, req, bus_a, vin_a);
    half = 1'b1; #1;
    chk(bus_b == vin_b[WB-1:WB/2], "R9 upper half", bus_b, vin_b[WB-1:WB/2]);
    half = 1'b0; #1;
    chk(bus_b == vin_b[WB/2-1:0], "R9 lower half", bus_b, vin_b[WB/2-1:0]);
    cs_n = 1'b1; cyc(4);
    chk(done_a && done_b, "R7 done high after strobe rise", {done_a, done_b}, 2'b11);
    chk(!oe_a && !oe_b, "R8 bus released on strobe rise", {oe_a, oe_b}, 2'b00);
    chk(pd_a == sd, "R6 power-down held after read", pd_a, sd);
  endtask

  initial begin
    cyc(3);
    idle_state("R1 reset state");
    rst_n = 1'b1; cyc(4);
    idle_state("R1 after reset release");

    // R2: ignored edge, then one acquisition edge must not convert
    strobe(1'b1);
    strobe(1'b0);
    cyc(WB + 8);
    chk(done_a && done_b, "R2 ignored edge did not count", {done_a, done_b}, 2'b11);
    rsel = 1'b0; cs_n = 1'b0; cyc(4); cs_n = 1'b1; cyc(WB + 8);
    chk(!done_a, "R2 conversion after acquisition", done_a, 0);
    rsel = 1'b1; cs_n = 1'b0; cyc(4); cs_n = 1'b1; cyc(4);

    // R5: zero input gives DATA_W one-hot trials starting at MSB
    vin_a = '0; vin_b = '0;
    cnt_a = 0; cnt_b = 0; mon_en = 1'b1;
    convert(1'b0, 1'b0);
    mon_en = 1'b0;
    chk(cnt_a == WA && first_a == WB'(1 << (WA-1)), "R5 trial order A", cnt_a, WA);
    chk(cnt_b == WB && first_b == 16'h8000, "R5 trial order B", cnt_b, WB);
    chk(trial_a == '0 && trial_b == '0, "R5 trial idle", trial_a, 0);
    read_check(1'b0, "R4 zero input");

    // R10: strobe activity mid-conversion, and low-mode edge after completion
    vin_a = 10'h2a5; vin_b = 16'hc3a5;
    convert(1'b1, 1'b1);
    strobe(1'b0);
    chk(!done_a && !oe_a && !oe_b, "R10 low-mode edge after done ignored", {done_a, oe_a}, 2'b00);
    read_check(1'b1, "R10 result intact");
    strobe(1'b0);
    chk(!pd_a && !pd_b, "R6 power-down cleared on acquisition", {pd_a, pd_b}, 2'b00);
    rsel = 1'b0; cs_n = 1'b0; cyc(4); cs_n = 1'b1; cyc(WB + 8);

    // R11: clear from the completed phase, then normal operation resumes
    clear = 1'b1; cyc(1); clear = 1'b0; cyc(1);
    idle_state("R11 clear");
    vin_a = '1; vin_b = '1;
    convert(1'b0, 1'b0);
    read_check(1'b0, "R11 conversion after clear full scale R4");

    // R4: exhaustive word-wide sweep alongside byte-wide codes
    for (int v = 0; v < (1 << WA); v++) begin
      vin_a = WA'(v);
      vin_b = WB'(v * 64 + (v % 64));
      convert(vin_a[0], 1'b0);
      read_check(vin_a[0], "R4 sweep result");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule